// File: doc/BRIEF.md
# ADC Result Byte Output Formatter

This block takes 16-bit conversion results and places them on an 8-bit output bus. Each result enters with a one-cycle strobe. A result pipeline with a configurable depth delays it. A small sequencer then puts it on the bus. In the default two-byte mode, the bus carries the upper byte in one ADC clock cycle and the lower byte in the next. A byte-phase output lets a capturing device pair the two bytes back into a word. In single-byte mode, only the upper byte of each result is shown, and it is held until a newer result arrives. An active-low output enable releases the bus without disturbing the sequence behind it.

The sequencer has three states:
- `ST_IDLE`: no result has arrived since reset. The bus value is zero.
- `ST_HI`: the upper byte of the held word is on the bus.
- `ST_LO`: the lower byte of the held word is on the bus.

The transitions are:
- **load**: a result leaving the pipeline moves any state to `ST_HI`.
- **split**: `ST_HI` moves to `ST_LO` in two-byte mode when the mode has not just changed.
- **hold**: `ST_HI` stays in `ST_HI` in single-byte mode, or in the cycle in which the mode bit changes.
- **wrap**: `ST_LO` always returns to `ST_HI`.
- **wait**: `ST_IDLE` stays in `ST_IDLE` until the first result.

Top module: `adc_byte_fmt`

## Requirements
- R1: After reset, with the output enable low, the bus shows 8'h00, `byte_phase` is 1 and `bus_en` is 1.
- R2: In two-byte mode (`single_byte` = 0), a result is shown as its bits 15..8 and then its bits 7..0 in consecutive cycles. Result bit 15 appears on `dout[7]` and result bit 8 on `dout[0]`.
- R3: In single-byte mode (`single_byte` = 1), only bits 15..8 of the latest result are shown. They stay unchanged on later cycles until a new result arrives, and `byte_phase` stays 1.
- R4: A result strobed on the edge that samples `res_valid` first reaches the bus after `LATENCY` rising edges, counting that sampling edge as the first. The cycle before, the bus still shows its previous value.
- R5: `byte_phase` is 1 while an upper byte (or the idle value) is shown and 0 while a lower byte is shown. In two-byte mode, once a result is held, the phase toggles on every edge, and the held word is shown again if no new result arrives.
- R6: While `oe_n` is 1, `bus_en` is 0 and the bus is released. The byte sequence keeps advancing, so after `oe_n` returns to 0 the bus shows the byte of the current phase.
- R7: After the mode bit changes, the next byte shown is the upper byte of the held word.
- R8: A new result leaving the pipeline takes priority over a pending lower byte. The new upper byte is shown in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 16 | Conversion result |
| res_valid | input | 1 | One-cycle strobe marking `res_data` valid |
| single_byte | input | 1 | 1 = upper byte only, 0 = two-byte output |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 8 | Output byte bus, released when disabled |
| bus_en | output | 1 | 1 while the bus is driven |
| byte_phase | output | 1 | 1 = upper byte, 0 = lower byte |

## Verification
A strobe sampled on one edge produces its upper byte after `LATENCY` edges and its lower byte one edge later. A change of the mode bit takes effect at the next edge. The enable acts on `bus_en` and the bus with no clock involved. The bench drives every input on the falling edge and samples on a later falling edge, counted from the strobe for each of these delays. It also checks the cycle just before the first byte is due, to confirm the bus has not moved early.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // The sequencer register supplies the last cycle of latency.
    localparam int STAGES = LATENCY - 1;

    generate
        if (STAGES == 0) begin : g_direct
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_shift
            logic [STAGES-1:0] v_sr;
            logic [DATA_W-1:0] d_sr [STAGES];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_sr <= '0;
                    for (int i = 0; i < STAGES; i++) d_sr[i] <= '0;
                end else begin
                    v_sr[0] <= in_valid;
                    d_sr[0] <= in_data;
                    for (int i = 1; i < STAGES; i++) begin
                        v_sr[i] <= v_sr[i-1];
                        d_sr[i] <= d_sr[i-1];
                    end
                end
            end

            assign out_valid = v_sr[STAGES-1];
            assign out_data  = d_sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc_fmt_seq.sv
module adc_fmt_seq
    import adc_fmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [DATA_W-1:0]   word_data,
    input  logic                single_byte,
    output logic [DATA_W/2-1:0] byte_o,
    output logic                phase_o
);
    localparam int BYTE_W = DATA_W / 2;

    seq_state_t        st_q, st_d;
    logic [DATA_W-1:0] word_q;
    logic              mode_q;
    logic              mode_chg;

    assign mode_chg = (single_byte != mode_q);

    always_comb begin
        st_d = st_q;
        if (word_valid) begin
            st_d = ST_HI;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_HI:   st_d = (single_byte || mode_chg) ? ST_HI : ST_LO;
                ST_LO:   st_d = ST_HI;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            word_q <= '0;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= single_byte;
            if (word_valid) word_q <= word_data;
        end
    end

    always_comb begin
        byte_o  = '0;
        phase_o = 1'b1;
        unique case (st_q)
            ST_IDLE: begin byte_o = '0;                      phase_o = 1'b1; end
            ST_HI:   begin byte_o = word_q[DATA_W-1:BYTE_W]; phase_o = 1'b1; end
            ST_LO:   begin byte_o = word_q[BYTE_W-1:0];      phase_o = 1'b0; end
            default: begin byte_o = '0;                      phase_o = 1'b1; end
        endcase
    end

    AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LO) |-> ($past(st_q) == ST_HI)); // R2
    AST_SINGLE_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        single_byte |=> (st_q != ST_LO)); // R3
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (single_byte && mode_q && !word_valid && st_q != ST_IDLE) |=> $stable(byte_o)); // R3
    AST_NEW_WORD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> (phase_o && byte_o == $past(word_data[DATA_W-1:BYTE_W]))); // R8
endmodule

// File: rtl/adc_fmt_drv.sv
module adc_fmt_drv #(
    parameter int BYTE_W = 8
) (
    input  logic              oe_n,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] dout,
    output logic              bus_en
);
    assign bus_en = ~oe_n;
    assign dout   = bus_en ? byte_i : {BYTE_W{1'bz}};
endmodule

// File: rtl/adc_byte_fmt.sv
module adc_byte_fmt #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    input  logic              single_byte,
    input  logic              oe_n,
    output logic [DATA_W/2-1:0] dout,
    output logic              bus_en,
    output logic              byte_phase
);
    localparam int BYTE_W = DATA_W / 2;

    logic              pv;
    logic [DATA_W-1:0] pw;
    logic [BYTE_W-1:0] seq_byte;

    adc_fmt_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY)) i_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(res_valid), .in_data(res_data),
        .out_valid(pv), .out_data(pw)
    );

    adc_fmt_seq #(.DATA_W(DATA_W)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .word_valid(pv), .word_data(pw),
        .single_byte(single_byte),
        .byte_o(seq_byte), .phase_o(byte_phase)
    );

    adc_fmt_drv #(.BYTE_W(BYTE_W)) i_drv (
        .oe_n(oe_n), .byte_i(seq_byte),
        .dout(dout), .bus_en(bus_en)
    );

    AST_PHASE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_phase |=> byte_phase); // R5
endmodule

// File: tb/test_adc_byte_fmt.sv
module test_adc_byte_fmt;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] res_data = '0;
    logic        res_valid = 1'b0;
    logic        single_byte = 1'b0;
    logic        oe_n = 1'b0;
    logic [7:0]  dout;
    logic        bus_en;
    logic        byte_phase;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_byte_fmt #(.DATA_W(16), .LATENCY(LAT)) i_adc_byte_fmt (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .single_byte(single_byte), .oe_n(oe_n),
        .dout(dout), .bus_en(bus_en), .byte_phase(byte_phase)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; res_valid = 1'b0; single_byte = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Strobe one word; returns at the falling edge after the sampling edge.
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        res_valid = 1'b1; res_data = w;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 dout", dout, 8'h00);
        chk("R1 phase", {7'd0, byte_phase}, 8'h01);
        chk("R1 bus_en", {7'd0, bus_en}, 8'h01);
    endtask

    task automatic t_two_byte();
        do_reset();
        send(16'h8001);
        repeat (LAT - 2) @(negedge clk);
        chk("R4 not yet", dout, 8'h00);
        @(negedge clk);
        chk("R4 R2 high byte", dout, 8'h80);
        chk("R5 phase high", {7'd0, byte_phase}, 8'h01);
        @(negedge clk);
        chk("R2 low byte", dout, 8'h01);
        chk("R5 phase low", {7'd0, byte_phase}, 8'h00);
        @(negedge clk);
        chk("R5 repeat high", dout, 8'h80);
        @(negedge clk);
        chk("R5 repeat low", dout, 8'h01);
    endtask

    task automatic t_single();
        do_reset();
        single_byte = 1'b1;
        send(16'hC35A);
        repeat (LAT - 1) @(negedge clk);
        chk("R3 upper byte", dout, 8'hC3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 held", dout, 8'hC3);
            chk("R3 phase", {7'd0, byte_phase}, 8'h01);
        end
    endtask

    task automatic t_preempt();
        do_reset();
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'h1234;
        @(negedge clk);
        res_data = 16'hABCD;
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
        chk("R8 first high", dout, 8'h12);
        @(negedge clk);
        chk("R8 preempt high", dout, 8'hAB);
        chk("R8 phase", {7'd0, byte_phase}, 8'h01);
        @(negedge clk);
        chk("R8 low of new", dout, 8'hCD);
    endtask

    task automatic t_mode_change();
        do_reset();
        send(16'h5AA5);
        repeat (LAT - 1) @(negedge clk);
        chk("R7 start high", dout, 8'h5A);
        @(negedge clk);
        chk("R7 low", dout, 8'hA5);
        single_byte = 1'b1;
        @(negedge clk);
        chk("R7 to single high", dout, 8'h5A);
        chk("R7 phase", {7'd0, byte_phase}, 8'h01);
        single_byte = 1'b0;
        @(negedge clk);
        chk("R7 to double high", dout, 8'h5A);
        @(negedge clk);
        chk("R7 then low", dout, 8'hA5);
    endtask

    task automatic t_oe();
        do_reset();
        send(16'h9E3C);
        repeat (LAT - 1) @(negedge clk);
        chk("R6 high", dout, 8'h9E);
        oe_n = 1'b1;
        #1;
        chk("R6 bus_en off", {7'd0, bus_en}, 8'h00);
        @(negedge clk);
        chk("R6 phase advances", {7'd0, byte_phase}, 8'h00);
        oe_n = 1'b0;
        #1;
        chk("R6 bus_en on", {7'd0, bus_en}, 8'h01);
        chk("R6 current low", dout, 8'h3C);
        @(negedge clk);
        chk("R6 next high", dout, 8'h9E);
    endtask

    initial begin
        t_reset();
        t_two_byte();
        t_single();
        t_preempt();
        t_mode_change();
        t_oe();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule